// File: doc/BRIEF.md
# Single-cycle processor core

This block executes one instruction per clock. In the same cycle it fetches up to six instruction bytes at the current PC and splits them into fields. It then reads two operands from an eight-entry register file, runs the ALU, performs at most one data-memory access and works out the next PC. The PC, the condition codes, the status register, the register file and any data-memory write all change together on the rising clock edge. Everything between those edges is combinational.

Instruction memory and data memory sit outside the core and answer combinationally. The core drives the instruction address and receives six bytes, with the byte at the PC on bits [7:0]. It drives a byte address, write data and separate read and write strobes to the data memory, and takes the read word back in the same cycle. Subroutine linkage uses a stack held in data memory, and register 4 is the stack pointer. Call, return, push and pop change that pointer through the ALU by minus or plus four.

A halt, an undefined opcode or an unsupported function code stops the core. The status output then shows why, and no state changes again until reset.

Top module: `seq_core`

## Requirements
- R1: Byte 0 of an instruction holds the opcode in [7:4] and the function in [3:0]. Opcodes are 0 halt, 1 nop, 2 register move, 3 immediate move, 4 store, 5 load, 6 ALU, 7 jump, 8 call, 9 return, 10 push and 11 pop. Register-using forms (2,3,4,5,6,10,11) carry a register byte, with rA in [7:4] and rB in [3:0]. Immediate moves, stores, loads, jumps and calls carry a little-endian 32-bit constant after that. The fall-through PC adds 1, plus 1 for a register byte, plus 4 for a constant.
- R2: After reset the PC equals RESET_PC, the status is 0 (running) and the flags {Z,S,O} are 3'b100.
- R3: ALU function 0 adds, 1 subtracts, 2 ands and 3 xors, computing rB OP rA into rB. Only this opcode loads Z, S and O. O flags signed overflow of the add or the subtract and is 0 for the logical functions.
- R4: A register move copies rA into rB. An immediate move writes the constant into rB. A register ID of 8 or more reads as zero and disables the write.
- R5: A store writes rA to address rB+constant. A load places the word at rB+constant into rA. The read strobe is raised only by load, pop and return, the write strobe only by store, push and call, and never both together.
- R6: Jump functions are 0 always, 1 less-or-equal, 2 less, 3 equal, 4 not-equal, 5 greater-or-equal and 6 greater, tested on the signed flags. The next PC priority is call to its constant, then a taken jump to its constant, then return to the loaded word, and otherwise the fall-through address.
- R7: A call reduces the stack pointer by 4, stores the fall-through address at the new stack pointer and continues at its constant.
- R8: A return reads the word at the old stack pointer, adds 4 to the stack pointer and continues at the word it read.
- R9: A push stores rA at the stack pointer minus 4 and lowers the pointer by 4. A pop loads rA from the stack pointer and raises the pointer by 4. When a pop targets the stack pointer itself, the loaded word wins.
- R10: A halt sets the status to 1. The PC stays on the halt, and after that no register, flag, PC or memory write takes place.
- R11: An opcode above 11, an ALU function above 3 or a jump function above 6 sets the status to 2. The PC stays on that byte and no later instruction executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Current PC, used as the instruction fetch address |
| imem_bytes_i | input | 48 | Six instruction bytes starting at the PC, first byte in [7:0] |
| dmem_addr_o | output | 32 | Data memory byte address |
| dmem_wdata_o | output | 32 | Data memory write word |
| dmem_we_o | output | 1 | Data memory write strobe, taken at the clock edge |
| dmem_re_o | output | 1 | Data memory read strobe |
| dmem_rdata_i | input | 32 | Word read from data memory in the same cycle |
| cc_o | output | 3 | Flags {Z,S,O} |
| stat_o | output | 2 | 0 running, 1 halted, 2 invalid instruction |

## Verification
The bench builds the core with its default parameters: eight registers, stack pointer ID 4 and reset PC 0. With eight registers, ID 8 is the first ID past the file. A write to it shows whether the ID is checked as out of range or truncated onto register 0. The stack pointer starts just below the top of the model's 64-word data memory, so call, push and pop all land on its last word, where a wrong offset shows up as a different value. The programs cover a pop into the stack pointer, a taken and a not-taken branch on equal and on signed-less conditions, and both forms of invalid instruction.

// File: rtl/seq_core_pkg.sv
package seq_core_pkg;
  localparam int WORD_W = 32;
  localparam int ID_W   = 4;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_NOP   = 4'h1;
  localparam logic [3:0] OP_MOVRR = 4'h2;
  localparam logic [3:0] OP_MOVIR = 4'h3;
  localparam logic [3:0] OP_STORE = 4'h4;
  localparam logic [3:0] OP_LOAD  = 4'h5;
  localparam logic [3:0] OP_ALU   = 4'h6;
  localparam logic [3:0] OP_JUMP  = 4'h7;
  localparam logic [3:0] OP_CALL  = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hA;
  localparam logic [3:0] OP_POP   = 4'hB;

  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_HALT = 2'd1, ST_BAD = 2'd2} status_e;
  typedef enum logic [1:0] {FN_ADD = 2'd0, FN_SUB = 2'd1, FN_AND = 2'd2, FN_XOR = 2'd3} alu_fn_e;
  typedef enum logic [1:0] {SEL_VALA, SEL_VALC, SEL_MINUS4, SEL_PLUS4} alu_a_sel_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } cc_t;

  typedef struct packed {
    logic            valid;
    logic            is_halt;
    logic            need_regs;
    logic            need_const;
    logic [ID_W-1:0] src_a;
    logic [ID_W-1:0] src_b;
    logic [ID_W-1:0] dst_e;
    logic [ID_W-1:0] dst_m;
    alu_a_sel_e      alu_a_sel;
    logic            b_zero;
    alu_fn_e         alu_fn;
    logic            set_cc;
    logic            mem_re;
    logic            mem_we;
    logic            addr_from_a;
    logic            wdata_from_p;
    logic            is_jump;
    logic            is_call;
    logic            is_ret;
  } ctrl_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_core_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int SP_ID = 4
) (
  input  logic [3:0]      icode_i,
  input  logic [3:0]      ifun_i,
  input  logic [ID_W-1:0] ra_i,
  input  logic [ID_W-1:0] rb_i,
  output ctrl_t           ctrl_o
);
  localparam logic [ID_W-1:0] ID_NONE = ID_W'(NREG);
  localparam logic [ID_W-1:0] ID_SP   = ID_W'(SP_ID);

  always_comb begin
    ctrl_o           = '0;
    ctrl_o.src_a     = ID_NONE;
    ctrl_o.src_b     = ID_NONE;
    ctrl_o.dst_e     = ID_NONE;
    ctrl_o.dst_m     = ID_NONE;
    ctrl_o.alu_a_sel = SEL_VALA;
    ctrl_o.alu_fn    = FN_ADD;
    ctrl_o.valid     = 1'b1;
    case (icode_i)
      OP_HALT: ctrl_o.is_halt = 1'b1;
      OP_NOP:  ;
      OP_MOVRR: begin
        ctrl_o.need_regs = 1'b1;
        ctrl_o.src_a     = ra_i;
        ctrl_o.dst_e     = rb_i;
        ctrl_o.b_zero    = 1'b1;
      end
      OP_MOVIR: begin
        ctrl_o.need_regs  = 1'b1;
        ctrl_o.need_const = 1'b1;
        ctrl_o.dst_e      = rb_i;
        ctrl_o.alu_a_sel  = SEL_VALC;
        ctrl_o.b_zero     = 1'b1;
      end
      OP_STORE: begin
        ctrl_o.need_regs  = 1'b1;
        ctrl_o.need_const = 1'b1;
        ctrl_o.src_a      = ra_i;
        ctrl_o.src_b      = rb_i;
        ctrl_o.alu_a_sel  = SEL_VALC;
        ctrl_o.mem_we     = 1'b1;
      end
      OP_LOAD: begin
        ctrl_o.need_regs  = 1'b1;
        ctrl_o.need_const = 1'b1;
        ctrl_o.src_b      = rb_i;
        ctrl_o.alu_a_sel  = SEL_VALC;
        ctrl_o.mem_re     = 1'b1;
        ctrl_o.dst_m      = ra_i;
      end
      OP_ALU: begin
        ctrl_o.valid     = (ifun_i < 4'd4);
        ctrl_o.need_regs = 1'b1;
        ctrl_o.src_a     = ra_i;
        ctrl_o.src_b     = rb_i;
        ctrl_o.dst_e     = rb_i;
        ctrl_o.alu_fn    = alu_fn_e'(ifun_i[1:0]);
        ctrl_o.set_cc    = 1'b1;
      end
      OP_JUMP: begin
        ctrl_o.valid      = (ifun_i < 4'd7);
        ctrl_o.need_const = 1'b1;
        ctrl_o.is_jump    = 1'b1;
      end
      OP_CALL: begin
        ctrl_o.need_const   = 1'b1;
        ctrl_o.src_b        = ID_SP;
        ctrl_o.dst_e        = ID_SP;
        ctrl_o.alu_a_sel    = SEL_MINUS4;
        ctrl_o.mem_we       = 1'b1;
        ctrl_o.wdata_from_p = 1'b1;
        ctrl_o.is_call      = 1'b1;
      end
      OP_RET: begin
        ctrl_o.src_a       = ID_SP;
        ctrl_o.src_b       = ID_SP;
        ctrl_o.dst_e       = ID_SP;
        ctrl_o.alu_a_sel   = SEL_PLUS4;
        ctrl_o.mem_re      = 1'b1;
        ctrl_o.addr_from_a = 1'b1;
        ctrl_o.is_ret      = 1'b1;
      end
      OP_PUSH: begin
        ctrl_o.need_regs = 1'b1;
        ctrl_o.src_a     = ra_i;
        ctrl_o.src_b     = ID_SP;
        ctrl_o.dst_e     = ID_SP;
        ctrl_o.alu_a_sel = SEL_MINUS4;
        ctrl_o.mem_we    = 1'b1;
      end
      OP_POP: begin
        ctrl_o.need_regs   = 1'b1;
        ctrl_o.src_a       = ID_SP;
        ctrl_o.src_b       = ID_SP;
        ctrl_o.dst_e       = ID_SP;
        ctrl_o.dst_m       = ra_i;
        ctrl_o.alu_a_sel   = SEL_PLUS4;
        ctrl_o.mem_re      = 1'b1;
        ctrl_o.addr_from_a = 1'b1;
      end
      default: ctrl_o.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile
  import seq_core_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ID_W-1:0]   rd_a_i,
  input  logic [ID_W-1:0]   rd_b_i,
  output logic [WORD_W-1:0] val_a_o,
  output logic [WORD_W-1:0] val_b_o,
  input  logic [ID_W-1:0]   dst_e_i,
  input  logic [WORD_W-1:0] wd_e_i,
  input  logic [ID_W-1:0]   dst_m_i,
  input  logic [WORD_W-1:0] wd_m_i
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [WORD_W-1:0] regs_q [NREG];

  assign val_a_o = (rd_a_i < ID_W'(NREG)) ? regs_q[rd_a_i[IDX_W-1:0]] : '0;
  assign val_b_o = (rd_b_i < ID_W'(NREG)) ? regs_q[rd_b_i[IDX_W-1:0]] : '0;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[g] <= '0;
      else if (en_i && dst_m_i == ID_W'(g))      regs_q[g] <= wd_m_i;  // port M wins
      else if (en_i && dst_e_i == ID_W'(g))      regs_q[g] <= wd_e_i;
    end
  end

  assert_m_port_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dst_e_i == dst_m_i && dst_m_i < ID_W'(NREG))
      |=> regs_q[$past(dst_m_i[IDX_W-1:0])] == $past(wd_m_i));

  assert_disabled_read_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_i >= ID_W'(NREG)) |-> (val_a_o == '0));
endmodule

// File: rtl/seq_alu.sv
module seq_alu
  import seq_core_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  alu_fn_e           fn_i,
  output logic [WORD_W-1:0] res_o,
  output cc_t               cc_o
);
  localparam int MSB = WORD_W - 1;

  always_comb begin
    cc_o.of = 1'b0;
    unique case (fn_i)
      FN_ADD: begin
        res_o   = b_i + a_i;
        cc_o.of = (a_i[MSB] == b_i[MSB]) && (res_o[MSB] != b_i[MSB]);
      end
      FN_SUB: begin
        res_o   = b_i - a_i;
        cc_o.of = (a_i[MSB] != b_i[MSB]) && (res_o[MSB] != b_i[MSB]);
      end
      FN_AND:  res_o = b_i & a_i;
      default: res_o = b_i ^ a_i;
    endcase
    cc_o.zf = (res_o == '0);
    cc_o.sf = res_o[MSB];
  end
endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_core_pkg::*;
#(
  parameter int               NREG     = 8,
  parameter int               SP_ID    = 4,
  parameter logic [WORD_W-1:0] RESET_PC = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [WORD_W-1:0]  imem_addr_o,
  input  logic [47:0]        imem_bytes_i,
  output logic [WORD_W-1:0]  dmem_addr_o,
  output logic [WORD_W-1:0]  dmem_wdata_o,
  output logic               dmem_we_o,
  output logic               dmem_re_o,
  input  logic [WORD_W-1:0]  dmem_rdata_i,
  output logic [2:0]         cc_o,
  output logic [1:0]         stat_o
);
  logic [WORD_W-1:0] pc_q, pc_d;
  cc_t               cc_q, cc_alu;
  status_e           stat_q;
  ctrl_t             ctrl;

  logic [3:0]        icode, ifun;
  logic [ID_W-1:0]   ra, rb;
  logic [WORD_W-1:0] val_c, val_p, val_a, val_b, val_e, alu_a, alu_b;
  logic              run, bch;

  // fetch
  assign icode = imem_bytes_i[7:4];
  assign ifun  = imem_bytes_i[3:0];
  assign ra    = imem_bytes_i[15:12];
  assign rb    = imem_bytes_i[11:8];
  assign val_c = ctrl.need_regs ? imem_bytes_i[47:16] : imem_bytes_i[39:8];
  assign val_p = pc_q + WORD_W'(1) + (ctrl.need_regs ? WORD_W'(1) : '0)
                      + (ctrl.need_const ? WORD_W'(4) : '0);

  seq_ctrl #(.NREG(NREG), .SP_ID(SP_ID)) u_ctrl (
    .icode_i(icode), .ifun_i(ifun), .ra_i(ra), .rb_i(rb), .ctrl_o(ctrl)
  );

  assign run = (stat_q == ST_RUN) && ctrl.valid && !ctrl.is_halt;

  // decode / write back
  seq_regfile #(.NREG(NREG)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(run),
    .rd_a_i(ctrl.src_a), .rd_b_i(ctrl.src_b),
    .val_a_o(val_a), .val_b_o(val_b),
    .dst_e_i(ctrl.dst_e), .wd_e_i(val_e),
    .dst_m_i(ctrl.dst_m), .wd_m_i(dmem_rdata_i)
  );

  // execute
  always_comb begin
    unique case (ctrl.alu_a_sel)
      SEL_VALA:   alu_a = val_a;
      SEL_VALC:   alu_a = val_c;
      SEL_MINUS4: alu_a = -WORD_W'(4);
      default:    alu_a = WORD_W'(4);
    endcase
  end
  assign alu_b = ctrl.b_zero ? '0 : val_b;

  seq_alu u_alu (.a_i(alu_a), .b_i(alu_b), .fn_i(ctrl.alu_fn), .res_o(val_e), .cc_o(cc_alu));

  always_comb begin
    logic lt;
    lt = cc_q.sf ^ cc_q.of;
    case (ifun)
      4'd0:    bch = 1'b1;
      4'd1:    bch = lt | cc_q.zf;
      4'd2:    bch = lt;
      4'd3:    bch = cc_q.zf;
      4'd4:    bch = ~cc_q.zf;
      4'd5:    bch = ~lt;
      4'd6:    bch = ~lt & ~cc_q.zf;
      default: bch = 1'b0;
    endcase
  end

  // memory
  assign dmem_addr_o  = ctrl.addr_from_a ? val_a : val_e;
  assign dmem_wdata_o = ctrl.wdata_from_p ? val_p : val_a;
  assign dmem_we_o    = run & ctrl.mem_we;
  assign dmem_re_o    = run & ctrl.mem_re;

  // next PC, priority order
  always_comb begin
    if (ctrl.is_call)             pc_d = val_c;
    else if (ctrl.is_jump && bch) pc_d = val_c;
    else if (ctrl.is_ret)         pc_d = dmem_rdata_i;
    else                          pc_d = val_p;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= RESET_PC;
      cc_q   <= '{zf: 1'b1, sf: 1'b0, of: 1'b0};
      stat_q <= ST_RUN;
    end else if (stat_q == ST_RUN) begin
      if (!ctrl.valid)       stat_q <= ST_BAD;
      else if (ctrl.is_halt) stat_q <= ST_HALT;
      else begin
        pc_q <= pc_d;
        if (ctrl.set_cc) cc_q <= cc_alu;
      end
    end
  end

  assign imem_addr_o = pc_q;
  assign cc_o        = cc_q;
  assign stat_o      = stat_q;

  assert_stopped_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q != ST_RUN) |=> ($stable(pc_q) && $stable(cc_q) && $stable(stat_q)));

  assert_stopped_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q != ST_RUN) |-> !dmem_we_o);

  assert_strobe_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({dmem_we_o, dmem_re_o}) <= 1);

  assert_call_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && icode == OP_CALL) |=> (pc_q == $past(val_c)));

  assert_ret_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && icode == OP_RET) |=> (pc_q == $past(dmem_rdata_i)));

  assert_cc_only_alu_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (icode != OP_ALU) |=> $stable(cc_q));

  assert_nop_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && icode == OP_NOP) |=> (pc_q == $past(pc_q) + WORD_W'(1)));
endmodule

// File: tb/tb_seq_core.sv
module tb_seq_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
  logic [47:0] imem_bytes;
  logic        dmem_we, dmem_re;
  logic [2:0]  cc;
  logic [1:0]  stat;

  logic [7:0]  imem [256];
  logic [31:0] dmem [64];
  int          ptr;
  int          n_checks = 0;
  int          n_errors = 0;

  always #10 clk = ~clk;

  seq_core dut (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_addr_o(imem_addr), .imem_bytes_i(imem_bytes),
    .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata),
    .dmem_we_o(dmem_we), .dmem_re_o(dmem_re), .dmem_rdata_i(dmem_rdata),
    .cc_o(cc), .stat_o(stat)
  );

  always_comb
    for (int k = 0; k < 6; k++) imem_bytes[8*k +: 8] = imem[imem_addr[7:0] + 8'(k)];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // program builders
  task automatic b(input logic [7:0] v); imem[ptr[7:0]] = v; ptr++; endtask
  task automatic w(input logic [31:0] v);
    for (int k = 0; k < 4; k++) b(v[8*k +: 8]);
  endtask
  task automatic movir(input logic [3:0] rb, input logic [31:0] v); b(8'h30); b({4'h8, rb}); w(v); endtask
  task automatic rr(input logic [7:0] op, input logic [3:0] ra, input logic [3:0] rb); b(op); b({ra, rb}); endtask
  task automatic mem(input logic [3:0] op, input logic [3:0] ra, input logic [3:0] rb, input logic [31:0] d);
    b({op, 4'h0}); b({ra, rb}); w(d);
  endtask
  task automatic dest(input logic [7:0] op, input logic [31:0] d); b(op); w(d); endtask

  task automatic clear();
    rst_n = 1'b0;
    ptr = 0;
    for (int i = 0; i < 256; i++) imem[i] = 8'h00;
    for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
    #1;
  endtask

  task automatic run();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 300 && stat == 2'd0; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    clear();
    @(negedge clk);
    check("R2 pc", imem_addr, 32'h0);
    check("R2 stat", {30'h0, stat}, 32'h0);
    check("R2 cc", {29'h0, cc}, 32'h4);
  endtask

  task automatic t_sub_halt();
    clear();
    movir(4'd0, 32'd5); movir(4'd1, 32'd3);
    rr(8'h61, 4'd0, 4'd1);
    mem(4'h4, 4'd1, 4'd7, 32'h40);
    b(8'h00);
    run();
    check("R3 sub result", dmem[16], 32'hFFFF_FFFE);
    check("R3 sub flags", {29'h0, cc}, 32'h2);
    check("R10 halt stat", {30'h0, stat}, 32'h1);
    check("R1 halt pc", imem_addr, 32'd20);
    dmem[16] = 32'h0;
    repeat (5) @(negedge clk);
    check("R10 pc frozen", imem_addr, 32'd20);
    check("R10 no more writes", dmem[16], 32'h0);
  endtask

  task automatic t_overflow();
    clear();
    movir(4'd2, 32'h7FFF_FFFF); movir(4'd3, 32'd1);
    rr(8'h60, 4'd3, 4'd2);
    mem(4'h4, 4'd2, 4'd7, 32'h40);
    b(8'h00);
    run();
    check("R3 add overflow value", dmem[16], 32'h8000_0000);
    check("R3 add overflow flags", {29'h0, cc}, 32'h3);
  endtask

  task automatic t_logic_move();
    clear();
    movir(4'd0, 32'hF0); movir(4'd1, 32'd3);
    rr(8'h61, 4'd0, 4'd1);            // r1 = 3 - 0xF0
    rr(8'h62, 4'd1, 4'd0);            // r0 = 0xF0 & r1 = 0x10
    rr(8'h63, 4'd3, 4'd3);            // r3 ^= r3 -> 0, Z
    rr(8'h20, 4'd1, 4'd6);            // r6 = r1
    mem(4'h4, 4'd6, 4'd7, 32'h40);
    mem(4'h4, 4'd0, 4'd7, 32'h44);
    b(8'h00);
    run();
    check("R4 register move", dmem[16], 32'hFFFF_FF13);
    check("R3 and result", dmem[17], 32'h10);
    check("R3 xor zero flags", {29'h0, cc}, 32'h4);
  endtask

  task automatic t_disabled_id();
    clear();
    movir(4'd8, 32'h55);
    mem(4'h4, 4'd0, 4'd7, 32'h40);
    b(8'h00);
    dmem[16] = 32'hDEAD;
    run();
    check("R4 id 8 write dropped", dmem[16], 32'h0);
  endtask

  task automatic t_branch_eq();
    clear();
    movir(4'd0, 32'd1); movir(4'd1, 32'd1);
    rr(8'h61, 4'd0, 4'd1);
    dest(8'h73, 32'd25);              // equal: taken
    movir(4'd2, 32'hBAD);
    movir(4'd2, 32'h600D);            // at 25
    dest(8'h74, 32'd0);               // not-equal: not taken
    mem(4'h4, 4'd2, 4'd7, 32'h44);
    b(8'h00);                         // at 42
    run();
    check("R6 taken equal", dmem[17], 32'h600D);
    check("R6 fall-through end", imem_addr, 32'd42);
  endtask

  task automatic t_branch_lt();
    clear();
    movir(4'd0, 32'd5); movir(4'd1, 32'd3);
    rr(8'h61, 4'd0, 4'd1);
    dest(8'h76, 32'd0);               // greater: not taken
    dest(8'h72, 32'd30);              // less: taken
    b(8'h00);                         // at 24, wrong path
    for (int i = 0; i < 5; i++) b(8'h10);
    b(8'h00);                         // at 30
    run();
    check("R6 signed less path", imem_addr, 32'd30);
  endtask

  task automatic t_call_ret();
    clear();
    movir(4'd4, 32'h100);
    dest(8'h80, 32'd40);
    mem(4'h4, 4'd0, 4'd7, 32'h48);    // at 11
    mem(4'h4, 4'd4, 4'd7, 32'h4C);
    b(8'h00);                         // at 23
    ptr = 40;
    movir(4'd0, 32'h77);
    b(8'h90);
    run();
    check("R7 return address on stack", dmem[63], 32'd11);
    check("R7 callee ran", dmem[18], 32'h77);
    check("R8 sp restored", dmem[19], 32'h100);
    check("R8 returned to caller", imem_addr, 32'd23);
  endtask

  task automatic t_push_pop();
    clear();
    movir(4'd4, 32'h100); movir(4'd1, 32'h1234);
    rr(8'hA0, 4'd1, 4'd8);
    rr(8'hB0, 4'd2, 4'd8);
    mem(4'h4, 4'd2, 4'd7, 32'h50);
    mem(4'h4, 4'd4, 4'd7, 32'h54);
    rr(8'hA0, 4'd1, 4'd8);
    rr(8'hB0, 4'd4, 4'd8);
    mem(4'h4, 4'd4, 4'd7, 32'h58);
    b(8'h00);
    run();
    check("R9 pushed word", dmem[63], 32'h1234);
    check("R9 popped word", dmem[20], 32'h1234);
    check("R9 sp balanced", dmem[21], 32'h100);
    check("R9 pop into sp", dmem[22], 32'h1234);
  endtask

  task automatic t_load();
    clear();
    movir(4'd3, 32'h20);
    mem(4'h5, 4'd5, 4'd3, 32'h40);
    mem(4'h4, 4'd5, 4'd7, 32'h64);
    b(8'h00);
    dmem[24] = 32'hCAFE_F00D;
    run();
    check("R5 load then store", dmem[25], 32'hCAFE_F00D);
  endtask

  task automatic t_invalid();
    clear();
    movir(4'd0, 32'd9);
    b(8'hC0);
    mem(4'h4, 4'd0, 4'd7, 32'h40);
    b(8'h00);
    dmem[16] = 32'h1111;
    run();
    check("R11 bad opcode stat", {30'h0, stat}, 32'h2);
    check("R11 bad opcode pc", imem_addr, 32'd6);
    check("R11 no later store", dmem[16], 32'h1111);
    clear();
    rr(8'h65, 4'd0, 4'd1);
    run();
    check("R11 bad alu function", {30'h0, stat}, 32'h2);
    check("R11 flags untouched", {29'h0, cc}, 32'h4);
  endtask

  initial begin
    #4_000_000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_sub_halt();
    t_overflow();
    t_logic_move();
    t_disabled_id();
    t_branch_eq();
    t_branch_lt();
    t_call_ret();
    t_push_pop();
    t_load();
    t_invalid();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule